// File: doc/BRIEF.md
# Swapping Differentiating DAC Controller

This block is the digital front end of a differentiating current DAC made of two binary-weighted
element banks, here called A and B. Every clock it takes one signed correction word. It drives the
code and polarity controls of both banks so that their summed current is the first difference of the
input stream, that is the new word minus the word before it.

The input word n is always played positive in the clock after it arrives, and negated in the clock
after that. In swapping mode, words with an even index since reset go to bank A and words with an odd
index go to bank B. Each bank therefore holds one word for two clocks, first positive and then
negative. A gain error in either bank then only adds a differenced, zero-mean error term, so element
mismatch is first-order shaped.

A build-time switch turns swapping off for comparison measurements. In that mode bank A always plays
the new word and bank B always plays the previous word, negated. Each bank is binary weighted, and the
weight of its top bit equals one unit element of the main converter. The analog switches, the latches
and the current sources sit outside this block.

Top module: `swap_diff_dac_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets both codes to zero, sets `a_neg` to 0 and `b_neg` to 1, and returns the sample index to even.
- R2: Each bank's signed contribution is its code when its negate flag is 0, and minus its code when the flag is 1. After the edge that captures word x[n], the sum of both contributions equals x[n] - x[n-1], where the word before the first word after reset counts as 0.
- R3: With swapping on, the edge that captures an even-indexed word gives bank A that word with negate 0, and gives bank B the previous word with negate 1. For an odd-indexed word the roles of A and B are reversed.
- R4: At every clock exactly one of `a_neg` and `b_neg` is 1.
- R5: With swapping on, every bank plays a code with negate 0 in one clock and the same code with negate 1 in the next clock. The running sum of one bank's signed contribution is therefore zero after every clock in which that bank is negated, and a gain mismatch leaves no DC error.
- R6: With swapping off, bank A always carries the newest word with negate 0, and bank B always carries the previous word with negate 1.
- R7: Codes are two's complement over CODE_W bits, and the full range is passed unchanged, including the most negative value (-64 and +63 at the default width). Negation is signalled only by the flag and never by changing the code.
- R8: A reset in the middle of a stream restores the R1 state. The first word after that reset is index 0 and goes to bank A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at rate fs |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | CODE_W | Signed correction word, captured on every rising edge |
| a_code | output | CODE_W | Registered code of bank A |
| a_neg | output | 1 | Bank A plays its code negated when 1 |
| b_code | output | CODE_W | Registered code of bank B |
| b_neg | output | 1 | Bank B plays its code negated when 1 |

## Verification
The word presented before a rising edge shows up as the positive code one edge later. It then shows up as the negated code of the same bank two edges later, so the difference that word contributes to becomes complete one edge after capture. The bench drives `din` on the falling edge and compares every output at the following falling edge against a model that holds the previous word and the even/odd index. The per-bank running sums are checked only in the clocks where that bank is negated, because that is the only point where its pair of samples is complete.

// File: rtl/sdd_pkg.sv
// Shared types for the swapping differentiating DAC controller.
// Assumes: two banks only, indexed 0 (A) and 1 (B).
package sdd_pkg;
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    localparam int NUM_BANKS = 2;
endpackage

// File: rtl/sdd_phase.sv
// Even/odd sample index tracker.
// Toggles on every clock out of reset; reset returns it to even.
// Assumes one input word per clock.
module sdd_phase
    import sdd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o
);
    // Flip the index parity once per captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= PH_EVEN;
        else        phase_o <= (phase_o == PH_EVEN) ? PH_ODD : PH_EVEN;
    end
endmodule

// File: rtl/sdd_hist.sv
// One-word history register: holds the word captured on the previous edge.
// Assumes the word before the first one after reset is zero.
module sdd_hist #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] prev_o
);
    // Remember the current word for use by the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= din;
    end
endmodule

// File: rtl/sdd_steer.sv
// Decides which bank plays the new word positive on the coming edge.
// pos_o[i] = 1 means bank i loads the new word with negate 0, and
// pos_o[i] = 0 means bank i loads the previous word with negate 1.
// Assumes exactly two banks; the result is always one-hot.
module sdd_steer
    import sdd_pkg::*;
#(
    parameter bit SWAP_EN = 1'b1
) (
    input  phase_e                 phase_i,
    output logic [NUM_BANKS-1:0]   pos_o
);
    // Bank A takes even words (or every word in bypass); bank B takes odd words when swapping.
    always_comb begin
        pos_o[0] = !SWAP_EN || (phase_i == PH_EVEN);
        pos_o[1] =  SWAP_EN && (phase_i == PH_ODD);
    end
endmodule

// File: rtl/sdd_bank.sv
// Output register pair (code and negate flag) for one DAC bank.
// Loads either the new word positive or the previous word negated.
// Assumes the caller guarantees only one bank loads the new word per edge.
module sdd_bank #(
    parameter int CODE_W  = 7,
    parameter bit RST_NEG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_new,
    input  logic [CODE_W-1:0] new_code,
    input  logic [CODE_W-1:0] old_code,
    output logic [CODE_W-1:0] code_o,
    output logic              neg_o
);
    // Register this bank's code and polarity for the next sample period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            neg_o  <= RST_NEG;
        end else if (take_new) begin
            code_o <= new_code;
            neg_o  <= 1'b0;
        end else begin
            code_o <= old_code;
            neg_o  <= 1'b1;
        end
    end
endmodule

// File: rtl/swap_diff_dac_ctrl.sv
// Top of the swapping differentiating DAC controller.
// Each clock: the new word is sent positive to one bank, and the previous word
// is sent negated to the other bank. The summed output is x[n] - x[n-1].
// With SWAP_EN the banks trade roles every clock; without it A is always positive.
// Assumes one signed word per clock; all outputs are registered on the same edge.
module swap_diff_dac_ctrl
    import sdd_pkg::*;
#(
    parameter int CODE_W  = 7,
    parameter bit SWAP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] a_code,
    output logic              a_neg,
    output logic [CODE_W-1:0] b_code,
    output logic              b_neg
);
    phase_e                 phase;
    logic [CODE_W-1:0]      prev_word;
    logic [NUM_BANKS-1:0]   pos_sel;
    logic [CODE_W-1:0]      bank_code [NUM_BANKS];
    logic [NUM_BANKS-1:0]   bank_neg;

    sdd_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    sdd_hist #(.CODE_W(CODE_W)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .prev_o (prev_word)
    );

    sdd_steer #(.SWAP_EN(SWAP_EN)) u_steer (
        .phase_i (phase),
        .pos_o   (pos_sel)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        sdd_bank #(
            .CODE_W  (CODE_W),
            .RST_NEG (gi == 1)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_new (pos_sel[gi]),
            .new_code (din),
            .old_code (prev_word),
            .code_o   (bank_code[gi]),
            .neg_o    (bank_neg[gi])
        );
    end

    // Map the bank array onto the named output ports.
    always_comb begin
        a_code = bank_code[0];
        a_neg  = bank_neg[0];
        b_code = bank_code[1];
        b_neg  = bank_neg[1];
    end
endmodule

// File: rtl/swap_diff_dac_ctrl_chk.sv
// Property checker for swap_diff_dac_ctrl, attached by bind.
// Counts edges since reset so that history-based checks start only when valid.
module swap_diff_dac_ctrl_chk #(
    parameter int CODE_W  = 7,
    parameter bit SWAP_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] din,
    input logic [CODE_W-1:0] a_code,
    input logic              a_neg,
    input logic [CODE_W-1:0] b_code,
    input logic              b_neg
);
    logic [1:0] run_cnt;

    // Saturating count of operating edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    logic [CODE_W-1:0] pos_code, neg_code;
    // Pick the code of the positive bank and of the negated bank.
    always_comb begin
        pos_code = a_neg ? b_code : a_code;
        neg_code = a_neg ? a_code : b_code;
    end

    // R4: exactly one bank negated
    p_one_negated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_neg, b_neg}) == 1);

    // R2: positive bank carries the word captured one edge ago
    p_pos_is_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd1) |-> (pos_code == $past(din)));

    // R2: negated bank carries the word captured two edges ago
    p_neg_is_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |-> (neg_code == $past(din, 2)));

    // R5: with swapping, bank A alternates polarity every clock
    p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (SWAP_EN && run_cnt >= 2'd2) |-> (a_neg != $past(a_neg)));

    // R5: a bank keeps its code when it turns negative
    p_pair_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (SWAP_EN && run_cnt >= 2'd2 && a_neg) |-> (a_code == $past(a_code)));

    // R6: without swapping, polarity roles never change
    p_bypass_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!SWAP_EN) |-> (!a_neg && b_neg));
endmodule

bind swap_diff_dac_ctrl swap_diff_dac_ctrl_chk #(
    .CODE_W  (CODE_W),
    .SWAP_EN (SWAP_EN)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .a_code (a_code),
    .a_neg  (a_neg),
    .b_code (b_code),
    .b_neg  (b_neg)
);

// File: tb/test_swap_diff_dac_ctrl.sv
// Self-checking bench: one swapping instance and one bypass instance share the stimulus.
module test_swap_diff_dac_ctrl;
    localparam int  CODE_W     = 7;
    localparam time CLK_PERIOD = 10ns;
    localparam int  GAIN_A     = 1013;   // bank A gain, mismatched
    localparam int  GAIN_B     = 1000;   // bank B gain, nominal
    localparam int  MAXV       = (1 << (CODE_W - 1)) - 1;
    localparam int  MINV       = -(1 << (CODE_W - 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] din = '0;
    logic [CODE_W-1:0] a_code, b_code, ya_code, yb_code;
    logic              a_neg, b_neg, ya_neg, yb_neg;

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 0;
    int  prev_m  = 0;     // model: previous word
    bit  odd_m   = 0;     // model: index parity
    int  cum_a   = 0;     // running signed sum, bank A (swap instance)
    int  cum_b   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swap_diff_dac_ctrl #(.CODE_W(CODE_W), .SWAP_EN(1'b1)) i_swap_diff_dac_ctrl (
        .clk(clk), .rst_n(rst_n), .din(din),
        .a_code(a_code), .a_neg(a_neg), .b_code(b_code), .b_neg(b_neg)
    );

    swap_diff_dac_ctrl #(.CODE_W(CODE_W), .SWAP_EN(1'b0)) i_swap_diff_dac_ctrl_bypass (
        .clk(clk), .rst_n(rst_n), .din(din),
        .a_code(ya_code), .a_neg(ya_neg), .b_code(yb_code), .b_neg(yb_neg)
    );

    function automatic int sval(input logic [CODE_W-1:0] c, input logic n);
        int v;
        v = int'($signed(c));
        return n ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // R1, R8: reset state on both instances
    task automatic check_reset(input string req);
        chk(a_code == '0, req, int'($signed(a_code)), 0);
        chk(b_code == '0, req, int'($signed(b_code)), 0);
        chk({a_neg, b_neg} == 2'b01, req, int'({a_neg, b_neg}), 1);
        chk(ya_code == '0 && yb_code == '0, req, int'($signed(ya_code)), 0);
        chk({ya_neg, yb_neg} == 2'b01, req, int'({ya_neg, yb_neg}), 1);
        prev_m = 0; odd_m = 0; cum_a = 0; cum_b = 0;
    endtask

    // Apply one word, then check both instances one edge later.
    task automatic step(input int x);
        int ea_code, eb_code, ea_neg, eb_neg, sum_s, sum_y, err_s;
        din = CODE_W'(x);
        @(posedge clk);
        @(negedge clk);
        if (!odd_m) begin ea_code = x; ea_neg = 0; eb_code = prev_m; eb_neg = 1; end
        else        begin ea_code = prev_m; ea_neg = 1; eb_code = x; eb_neg = 0; end
        // R3: steering with swapping on
        chk(int'($signed(a_code)) == ea_code, "R3", int'($signed(a_code)), ea_code);
        chk(int'($signed(b_code)) == eb_code, "R3", int'($signed(b_code)), eb_code);
        chk(int'(a_neg) == ea_neg && int'(b_neg) == eb_neg, "R3", int'(a_neg), ea_neg);
        // R4: exactly one negated bank
        chk((a_neg ^ b_neg) == 1'b1, "R4", int'({a_neg, b_neg}), 1);
        // R2: unity-gain difference on both instances
        sum_s = sval(a_code, a_neg) + sval(b_code, b_neg);
        sum_y = sval(ya_code, ya_neg) + sval(yb_code, yb_neg);
        chk(sum_s == x - prev_m, "R2", sum_s, x - prev_m);
        chk(sum_y == x - prev_m, "R2", sum_y, x - prev_m);
        // R6: bypass roles are fixed
        chk(int'($signed(ya_code)) == x && !ya_neg, "R6", int'($signed(ya_code)), x);
        chk(int'($signed(yb_code)) == prev_m && yb_neg, "R6", int'($signed(yb_code)), prev_m);
        // R5: mismatch error has zero DC; each bank's running sum closes per pair
        err_s = GAIN_A * sval(a_code, a_neg) + GAIN_B * sval(b_code, b_neg)
              - GAIN_B * (x - prev_m);
        cum_a += sval(a_code, a_neg);
        cum_b += sval(b_code, b_neg);
        if (a_neg) chk(cum_a == 0, "R5", cum_a, 0);
        if (b_neg) chk(cum_b == 0, "R5", cum_b, 0);
        chk(err_s == (GAIN_A - GAIN_B) * sval(a_code, a_neg), "R5", err_s,
            (GAIN_A - GAIN_B) * sval(a_code, a_neg));
        prev_m = x;
        odd_m  = !odd_m;
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240517);
        din = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R1");
        rst_n = 1'b1;

        // R7: full-scale extremes, alternating and repeated
        step(MINV); step(MAXV); step(MINV); step(MINV);
        step(MAXV); step(MAXV); step(0); step(MINV);
        chk(int'($signed(a_code)) == MINV || int'($signed(b_code)) == MINV, "R7",
            int'($signed(a_code)), MINV);
        // constant input: zero difference
        repeat (6) step(37);
        // random stream
        for (int i = 0; i < 150; i++) step(int'($signed(CODE_W'($urandom))));

        // R8: reset in mid-stream, index restarts even
        din = CODE_W'(5);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_reset("R8");
        rst_n = 1'b1;
        step(-9);
        chk(int'($signed(a_code)) == -9 && !a_neg, "R8", int'($signed(a_code)), -9);
        step(22);
        for (int i = 0; i < 120; i++) step(int'($signed(CODE_W'($urandom))));
        step(MINV); step(MAXV);
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule